// File: doc/BRIEF.md
# Page-Mode Parallel ROM Reader

This block is a synchronous read controller for an external asynchronous parallel read-only memory. The memory has a 20-bit word address. It can present either a 16-bit word or an 8-bit byte, and it returns data faster when successive reads stay inside one 8-word page. A client issues one request with a start address, an item count and a byte/word flag. The controller then drives the memory's address lines, active-low chip enable, active-low output enable and word/byte select. It waits a counted number of clock cycles before it samples the data bus, and it returns each item with a one-cycle valid strobe.

Every analog timing is a parameter in picoseconds. The controller turns each one into a cycle count, ceiling(time / clock period) plus one margin cycle. A read that stays in the current page uses the short page count. The first read of a request, and any read that enters a new page, uses the full random count. In byte mode the memory's top data pin acts as the least significant address bit. The controller drives it from bit 0 of the byte address and drives bits 20:1 onto the word address lines. A page is therefore 16 bytes in byte mode.

After the last item the controller raises both enables. It then waits for the bus to float before it accepts another request.

Top module: `prom_page_reader`

## Requirements
- R1: After reset, req_ready is 1, mem_ce_n and mem_oe_n are 1, and rd_valid is 0.
- R2: A request with nonzero req_len is accepted at a clock edge where req_valid and req_ready are both 1. req_ready is 0 from the next cycle. mem_ce_n and mem_oe_n fall at the accepting edge and stay low until the last item has been sampled.
- R3: The first item of a request is returned (rd_valid high) exactly RW+2 cycles after chip enable falls. RW = max(ceil(T_AA/Tclk), ceil(T_OE/Tclk)) + 1.
- R4: When the next address keeps word-address bits 19:3 unchanged, that item is returned exactly PW+1 cycles after the address change. PW = ceil(T_PA/Tclk) + 1.
- R5: When the next address changes word-address bits 19:3, that item is returned exactly RW+1 cycles after the address change.
- R6: In word mode (req_byte=0), mem_word_sel is 1 and mem_lsb is 0. Items are word addresses req_addr[19:0], +1, +2 and so on, wrapping from 20'hFFFFF to 0. rd_data is the full 16-bit bus.
- R7: In byte mode (req_byte=1), mem_word_sel is 0. Items are byte addresses req_addr[20:0] upward. mem_lsb carries byte-address bit 0 and mem_addr carries bits 20:1. rd_data[7:0] is bus bits 7:0 and rd_data[15:8] is 0.
- R8: A request returns exactly req_len items, in increasing address order, one rd_valid pulse per item.
- R9: After the last sample, mem_ce_n and mem_oe_n rise at the same edge. req_ready returns exactly HZ cycles later. HZ = ceil(T_HZ/Tclk) + 1.
- R10: A request with req_len = 0 is ignored: chip enable stays high, no item is returned and req_ready stays 1.
- R11: The address lines hold steady throughout every wait, and the bus is sampled only while both enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Controller idle, request may be taken |
| req_addr | input | 21 | Start address (word address in bits 19:0, or byte address) |
| req_len | input | 8 | Number of items to read |
| req_byte | input | 1 | 1 = byte mode, 0 = word mode |
| rd_valid | output | 1 | One-cycle strobe per returned item |
| rd_data | output | 16 | Returned item |
| mem_addr | output | 20 | Memory word address lines |
| mem_lsb | output | 1 | Byte-mode least significant address bit (shared data pin) |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_word_sel | output | 1 | Memory word/byte select, 1 = word |
| mem_bus | input | 16 | Memory data bus |

## Verification
The bench aims at page boundaries: word runs that start one or two words before a page end, byte runs that cross a 16-byte line, and the wrap of the word address from its top value to zero. If a design classified a crossing as in-page, the bench would see the short latency on an address that needs the full wait. If a design mapped the byte address wrongly, the bench would see wrong low-byte data. A request with zero length must leave chip enable high. A lingering upper byte in byte mode would show up as nonzero high data. A release that is too short would show req_ready returning early.

// File: rtl/prom_pkg.sv
package prom_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_RAND_WAIT, ST_PAGE_WAIT, ST_CAPTURE, ST_RELEASE
  } rd_state_t;

  // cycles to cover a delay, plus one margin cycle
  function automatic int unsigned span_cycles(input int unsigned t_ps,
                                              input int unsigned clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps + 1;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/prom_wait_timer.sv
module prom_wait_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - W'(1);
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/prom_addr_seq.sv
module prom_addr_seq #(
  parameter int AW = 20,
  parameter int PG = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          byte_mode,
  input  logic [AW:0]   start,
  output logic [AW-1:0] word_addr,
  output logic          lsb,
  output logic          step_in_page
);
  logic [AW:0]   cur, nxt;
  logic [AW-1:0] nxt_word;

  function automatic logic [AW-1:0] to_word(input logic [AW:0] a, input logic bm);
    return bm ? a[AW:1] : a[AW-1:0];
  endfunction

  always_comb begin
    if (byte_mode) nxt = cur + (AW+1)'(1);
    else           nxt = {1'b0, cur[AW-1:0] + AW'(1)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cur <= '0;
    else if (load)  cur <= byte_mode ? start : {1'b0, start[AW-1:0]};
    else if (step)  cur <= nxt;
  end

  assign word_addr    = to_word(cur, byte_mode);
  assign lsb          = byte_mode & cur[0];
  assign nxt_word     = to_word(nxt, byte_mode);
  assign step_in_page = (nxt_word[AW-1:PG] == word_addr[AW-1:PG]);
endmodule

// File: rtl/prom_page_reader.sv
module prom_page_reader
  import prom_pkg::*;
#(
  parameter int AW     = 20,
  parameter int DW     = 16,
  parameter int LEN_W  = 8,
  parameter int PG     = 3,
  parameter int CLK_PS = 10000,
  parameter int T_AA_PS = 100000,
  parameter int T_PA_PS = 30000,
  parameter int T_OE_PS = 30000,
  parameter int T_HZ_PS = 20000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_byte,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_lsb,
  output logic             mem_ce_n,
  output logic             mem_oe_n,
  output logic             mem_word_sel,
  input  logic [DW-1:0]    mem_bus
);
  localparam int unsigned RAND_CYC = max_u(span_cycles(T_AA_PS, CLK_PS),
                                           span_cycles(T_OE_PS, CLK_PS));
  localparam int unsigned PAGE_CYC = span_cycles(T_PA_PS, CLK_PS);
  localparam int unsigned HZ_CYC   = span_cycles(T_HZ_PS, CLK_PS);
  localparam int unsigned MAX_CYC  = max_u(RAND_CYC, max_u(PAGE_CYC, HZ_CYC));
  localparam int CW = $clog2(MAX_CYC + 1);
  localparam int HB = DW / 2;

  rd_state_t        state, nxt_state;
  logic [LEN_W-1:0] left_q;
  logic             byte_q;
  logic             tmr_load, tmr_expired;
  logic [CW-1:0]    tmr_val;

  // named internal events
  wire ev_accept  = (state == ST_IDLE) && req_valid && (req_len != '0);
  wire ev_capture = (state == ST_CAPTURE);
  wire ev_last    = ev_capture && (left_q == LEN_W'(1));
  wire ev_step    = ev_capture && !ev_last;
  wire in_page;

  prom_addr_seq #(.AW(AW), .PG(PG)) u_seq (
    .clk(clk), .rst_n(rst_n), .load(ev_accept), .step(ev_step),
    .byte_mode(ev_accept ? req_byte : byte_q), .start(req_addr),
    .word_addr(mem_addr), .lsb(mem_lsb), .step_in_page(in_page)
  );

  prom_wait_timer #(.W(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_expired)
  );

  always_comb begin
    nxt_state = state;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    unique case (state)
      ST_IDLE:      if (ev_accept) nxt_state = ST_SETUP;
      ST_SETUP: begin
        nxt_state = ST_RAND_WAIT;
        tmr_load  = 1'b1;
        tmr_val   = CW'(RAND_CYC - 1);
      end
      ST_RAND_WAIT, ST_PAGE_WAIT:
        if (tmr_expired) nxt_state = ST_CAPTURE;
      ST_CAPTURE: begin
        tmr_load = 1'b1;
        if (ev_last) begin
          nxt_state = ST_RELEASE;
          tmr_val   = CW'(HZ_CYC - 1);
        end else if (in_page) begin
          nxt_state = ST_PAGE_WAIT;
          tmr_val   = CW'(PAGE_CYC - 1);
        end else begin
          nxt_state = ST_RAND_WAIT;
          tmr_val   = CW'(RAND_CYC - 1);
        end
      end
      ST_RELEASE:   if (tmr_expired) nxt_state = ST_IDLE;
      default:      nxt_state = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      left_q   <= '0;
      byte_q   <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      state    <= nxt_state;
      rd_valid <= ev_capture;
      if (ev_accept) begin
        left_q <= req_len;
        byte_q <= req_byte;
      end
      if (ev_step) left_q <= left_q - LEN_W'(1);
      if (ev_capture)
        rd_data <= byte_q ? {{(DW-HB){1'b0}}, mem_bus[HB-1:0]} : mem_bus;
    end
  end

  assign req_ready    = (state == ST_IDLE);
  assign mem_ce_n     = (state == ST_IDLE) || (state == ST_RELEASE);
  assign mem_oe_n     = mem_ce_n;
  assign mem_word_sel = !byte_q;

  // R11: address steady during every wait
  p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_RAND_WAIT || state == ST_PAGE_WAIT) && $past(state) == state)
      |-> ($stable(mem_addr) && $stable(mem_lsb)));
  // R4: short wait only when the page bits kept their value
  p_page_wait_in_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PAGE_WAIT && $past(state) == ST_CAPTURE)
      |-> (mem_addr[AW-1:PG] == $past(mem_addr[AW-1:PG])));
  // R2: samples are taken only with both enables low
  p_sample_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!mem_ce_n && !mem_oe_n));
  // R9: idle returns only after chip enable has been high
  p_release_ce_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> ($past(mem_ce_n) && mem_ce_n));
  // R7: mode select does not move within a request
  p_mode_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !$past(req_ready)) |-> $stable(mem_word_sel));
  // R10: a zero-length request never leaves idle
  p_zero_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid && req_len == '0) |=> req_ready);
endmodule

// File: tb/prom_page_reader_bench.sv
`timescale 1ns/1ps
module prom_page_reader_bench;
  localparam int CLK_NS = 10;
  localparam int T_AA = 100, T_PA = 30, T_OE = 30, T_HZ = 20;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_byte = 1'b0;
  logic [20:0] req_addr = '0;
  logic [7:0]  req_len = '0;
  logic        req_ready, rd_valid, mem_lsb, mem_ce_n, mem_oe_n, mem_word_sel;
  logic [15:0] rd_data, mem_bus;
  logic [19:0] mem_addr;

  always #(CLK_NS/2) clk = ~clk;

  prom_page_reader #(.CLK_PS(CLK_NS*1000), .T_AA_PS(T_AA*1000), .T_PA_PS(T_PA*1000),
                     .T_OE_PS(T_OE*1000), .T_HZ_PS(T_HZ*1000)) u_prom_page_reader (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_byte(req_byte),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr), .mem_lsb(mem_lsb),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_word_sel(mem_word_sel),
    .mem_bus(mem_bus));

  // memory model: data is the address; floats high when disabled; junk upper byte in byte mode
  assign mem_bus = (mem_ce_n || mem_oe_n) ? 16'hFFFF :
                   mem_word_sel ? mem_addr[15:0] : {8'hA5, mem_addr[6:0], mem_lsb};

  int checks = 0, errors = 0;
  bit done = 0;

  function automatic int need(input int t);
    int k = 0;
    while (k * CLK_NS < t) k++;
    return k + 1;
  endfunction
  int RW, PW, HZ;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] word_of(input logic [20:0] a, input bit bm);
    return bm ? a[20:1] : a[19:0];
  endfunction
  function automatic logic [20:0] bump(input logic [20:0] a, input bit bm);
    return bm ? a + 21'd1 : {1'b0, a[19:0] + 20'd1};
  endfunction

  // monitor state
  logic [20:0] cur_exp;
  bit          cur_bm;
  int n = 0, t_start = 0, t_rel = 0, kind = 0, items = 0, seen_page = 0, seen_rand = 0;
  logic prev_ce = 1, prev_ready = 1, prev_lsb = 0;
  logic [19:0] prev_addr = '0;

  always @(negedge clk) if (rst_n) begin
    n++;
    if (rd_valid) begin
      logic [15:0] ed;
      int el;
      ed = cur_bm ? {8'h00, cur_exp[7:0]} : cur_exp[15:0];
      chk(rd_data == ed, cur_bm ? "R7 byte data" : "R6 word data", rd_data, ed);
      el = n - t_start;
      if (kind == 0)      chk(el == RW + 2, "R3 first latency", el, RW + 2);
      else if (kind == 1) chk(el == PW + 1, "R4 page latency", el, PW + 1);
      else                chk(el == RW + 1, "R5 cross latency", el, RW + 1);
      if (kind == 1) seen_page++; else seen_rand++;
      items++;
      cur_exp = bump(cur_exp, cur_bm);
    end
    if (prev_ce && !mem_ce_n) begin
      t_start = n; kind = 0;
      chk(!mem_oe_n, "R2 oe with ce", mem_oe_n, 0);
      chk(mem_addr == word_of(cur_exp, cur_bm) && mem_lsb == (cur_bm & cur_exp[0]),
          "R7 pin map", {mem_addr, mem_lsb}, {word_of(cur_exp, cur_bm), cur_bm & cur_exp[0]});
      chk(mem_word_sel == !cur_bm, "R6 word select", mem_word_sel, !cur_bm);
    end else if (!mem_ce_n && (mem_addr != prev_addr || mem_lsb != prev_lsb)) begin
      t_start = n;
      kind = (mem_addr[19:3] == prev_addr[19:3]) ? 1 : 2;
    end
    if (!prev_ce && mem_ce_n) begin
      t_rel = n;
      chk(mem_oe_n, "R9 oe rises with ce", mem_oe_n, 1);
    end
    if (!prev_ready && req_ready) chk(n - t_rel == HZ, "R9 release time", n - t_rel, HZ);
    prev_ce = mem_ce_n; prev_ready = req_ready; prev_addr = mem_addr; prev_lsb = mem_lsb;
  end

  task automatic do_req(input logic [20:0] a, input int len, input bit bm);
    int ep = 0, er = 0;
    logic [20:0] x;
    while (!req_ready) @(negedge clk);
    cur_exp = bm ? a : {1'b0, a[19:0]};
    cur_bm = bm; items = 0; seen_page = 0; seen_rand = 0;
    x = cur_exp;
    for (int i = 1; i < len; i++) begin
      logic [20:0] y;
      y = bump(x, bm);
      if (word_of(y, bm) >> 3 == word_of(x, bm) >> 3) ep++; else er++;
      x = y;
    end
    if (len > 0) er++;
    req_addr = a; req_len = 8'(len); req_byte = bm; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    if (len == 0) begin
      repeat (4) begin
        chk(mem_ce_n && req_ready, "R10 zero length idle", {mem_ce_n, req_ready}, 2'b11);
        @(negedge clk);
      end
    end else begin
      chk(!req_ready, "R2 busy after accept", req_ready, 0);
      while (!req_ready) @(negedge clk);
    end
    chk(items == len, "R8 item count", items, len);
    chk(seen_page == ep, "R4 page access count", seen_page, ep);
    chk(seen_rand == er, "R5 random access count", seen_rand, er);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    RW = (need(T_AA) > need(T_OE)) ? need(T_AA) : need(T_OE);
    PW = need(T_PA);
    HZ = need(T_HZ);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && mem_ce_n && mem_oe_n && !rd_valid, "R1 reset state",
        {req_ready, mem_ce_n, mem_oe_n, rd_valid}, 4'b1110);
    do_req(21'h00006, 4, 0);     // word, crosses page after two items
    do_req(21'h0FFFFE, 4, 0);    // word wrap 20'hFFFFF -> 0
    do_req(21'h0000E, 5, 1);     // byte, crosses 16-byte line
    do_req(21'h12345, 0, 0);     // R10 zero length
    do_req(21'h00010, 1, 0);
    do_req(21'h1FFFFF, 3, 1);    // byte wrap at top
    do_req(21'h00020, 16, 0);    // two full pages
    for (int i = 0; i < 30; i++)
      do_req(21'($urandom), 1 + int'($urandom % 20), bit'($urandom % 2));
    finish_run();
  end
endmodule